// File: doc/BRIEF.md
# Dual-Mode General-Purpose Timer

This block is a 32-bit timer peripheral that sits on a simple single-cycle register bus. An up-counter can run on every clock or through a power-of-two prescaler. When it passes all ones it either reloads a programmed start value or stops by itself. A compare unit flags the step on which the counter equals a programmed value. Overflow and compare events set sticky status bits that raise one interrupt line through an enable mask. The same events can drive one output pin as a single-cycle pulse or as a toggling square wave. That gives a timed interrupt source and a simple PWM generator from one counter.

Writes to the timing registers are posted. Software writes the value, then polls a pending register until it reads zero, and only then is the new value in force. A write of any value to the trigger address copies the start value into the counter. A software reset brings every register back to its reset value, and a reset-done flag tells software when the block can be used again. Status, interrupt-enable and reset-control writes act at once.

Top module: `gpt_timer`

## Requirements
- R1: After reset, control (0x24), counter (0x28), start value (0x2C), compare (0x38), status (0x18) and interrupt enable (0x1C) read 0, system status (0x14) bit 0 reads 1, and both `irq` and `pwm_out` are low.
- R2: Writes to control, counter, start value, trigger (0x30) and compare are posted. From the cycle after such a write until it takes effect, the pending register (0x34) reads a one-hot code (bit 0 control, bit 1 counter, bit 2 start value, bit 3 trigger, bit 4 compare), and the target still reads its old value. Once 0x34 reads 0, the new value is in force.
- R3: A write of any data to the trigger address loads the counter with the start value.
- R4: With control bit 0 set and bit 5 clear, the counter advances by one every clock. With bit 0 clear, it holds its value.
- R5: With control bit 5 set, the counter advances once every 2^(v+1) clocks, where v is control bits 4:2.
- R6: On a step from all ones, status bit 1 is set. If control bit 1 is set, the counter reloads the start value and keeps running. Otherwise it wraps to 0 and control bit 0 clears.
- R7: With control bit 6 set, status bit 0 is set on a step taken while the counter equals the compare value. With bit 6 clear, no compare event occurs.
- R8: Writing 1 to a status bit clears it. `irq` is high while any status bit is set whose bit in the interrupt enable register (0x1C) is also set. Both registers act the cycle after the write.
- R9: Control bits 11:10 pick the output events: 1 is overflow, 2 is overflow or compare, 0 and 3 are none. Control bit 12 set toggles the pin on each event. Clear gives a one-cycle pulse. Control bit 7 is the idle level, and the pin equals that level XOR the event state.
- R10: A write to 0x40 with data bit 1 set starts a software reset. From the next cycle, 0x14 bit 0 reads 0 until the reset ends, then reads 1, and all registers hold their reset values. A write to 0x40 with bit 1 clear has no effect, and bus writes are ignored while the reset runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Write strobe qualifier, sampled on the rising edge |
| bus_wr | input | 1 | Write when high together with `bus_req` |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request, level |
| pwm_out | output | 1 | Pulse or toggle output pin |

## Verification
A corrupted counter or start value shows up at the counter address within a single read, and a wrong overflow decision shows up at the control run bit and at status bit 1 on the next cycle. Errors in the prescaler divider appear as a wrong step count over a window of a few prescaler periods. A fault in the event-to-pin path shows as a wrong number of pulses or toggles within a few counter periods. A posting fault shows as a target that changes too early or a pending code that clears too soon, on the cycle right after the write.

// File: rtl/gpt_pkg.sv
package gpt_pkg;
  // register byte offsets; software relies on this map
  localparam int OFF_SYSST = 'h14;
  localparam int OFF_STAT  = 'h18;
  localparam int OFF_IEN   = 'h1C;
  localparam int OFF_CTRL  = 'h24;
  localparam int OFF_CNT   = 'h28;
  localparam int OFF_LOAD  = 'h2C;
  localparam int OFF_TRIG  = 'h30;
  localparam int OFF_PEND  = 'h34;
  localparam int OFF_MATCH = 'h38;
  localparam int OFF_CAPT  = 'h3C;
  localparam int OFF_IFC   = 'h40;

  // control field positions
  localparam int CTRL_W    = 15;
  localparam int CB_RUN    = 0;
  localparam int CB_AUTO   = 1;
  localparam int CB_DIV_LO = 2;
  localparam int CB_DIV_EN = 5;
  localparam int CB_CMP_EN = 6;
  localparam int CB_IDLE   = 7;
  localparam int CB_EVT_LO = 10;
  localparam int CB_TOGGLE = 12;

  // status bits
  localparam int STAT_W    = 3;
  localparam int SB_CMP    = 0;
  localparam int SB_OVF    = 1;

  // pending code bits
  localparam int PEND_W    = 5;
endpackage

// File: rtl/gpt_post.sv
module gpt_post #(
  parameter int AW  = 8,
  parameter int DW  = 32,
  parameter int LAT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          apply,
  output logic [AW-1:0] ap_addr,
  output logic [DW-1:0] ap_data
);
  localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    addr_d = addr_q;
    data_d = data_q;
    if (clr) begin
      busy_d = 1'b0;
    end else if (wr_en) begin
      busy_d = 1'b1;
      cnt_d  = CW'(LAT - 1);
      addr_d = wr_addr;
      data_d = wr_data;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign busy    = busy_q;
  assign apply   = busy_q && (cnt_q == '0) && !clr && !wr_en;
  assign ap_addr = addr_q;
  assign ap_data = data_q;
endmodule

// File: rtl/gpt_prescale.sv
module gpt_prescale #(
  parameter int DIV_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       div_en,
  input  logic [2:0] div_sel,
  output logic       tick
);
  logic [DIV_W-1:0] div_q, div_d, limit;
  logic             wrap;

  always_comb begin
    limit = ~({DIV_W{1'b1}} << ({1'b0, div_sel} + 4'd1));
    wrap  = (div_q >= limit);
    tick  = run && (!div_en || wrap);
    if (!run || !div_en || wrap) div_d = '0;
    else                         div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/gpt_pwm.sv
module gpt_pwm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       ovf_ev,
  input  logic       cmp_ev,
  input  logic [1:0] evt_sel,
  input  logic       toggle,
  input  logic       idle_lvl,
  output logic       pwm_out
);
  logic st_q, st_d, hit, active;

  always_comb begin
    active = (evt_sel == 2'd1) || (evt_sel == 2'd2);
    hit    = ((evt_sel == 2'd1) && ovf_ev) ||
             ((evt_sel == 2'd2) && (ovf_ev || cmp_ev));
    if (clr || !active) st_d = 1'b0;
    else if (toggle)    st_d = st_q ^ hit;
    else                st_d = hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= 1'b0;
    else        st_q <= st_d;
  end

  assign pwm_out = st_q ^ idle_lvl;
endmodule

// File: rtl/gpt_timer.sv
module gpt_timer
  import gpt_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int POST_LAT = 3,
  parameter int SR_LAT   = 8,
  parameter int DIV_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              pwm_out
);
  localparam int SRW = (SR_LAT > 1) ? $clog2(SR_LAT) : 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DATA_W-1:0] cnt_q, cnt_d, load_q, load_d, match_q, match_d;
  logic [STAT_W-1:0] stat_q, stat_d, ien_q, ien_d, stat_w1c;
  logic              sr_busy_q, sr_busy_d;
  logic [SRW-1:0]    sr_cnt_q, sr_cnt_d;

  logic              wr_ok, wr_posted, sr_go, clr;
  logic              post_busy, post_apply;
  logic [ADDR_W-1:0] ap_addr;
  logic [DATA_W-1:0] ap_data;
  logic              ap_ctrl, ap_cnt, ap_load, ap_trig, ap_match;
  logic              tick, ovf_ev, cmp_ev;
  logic [PEND_W-1:0] pend_code;

  assign clr   = sr_busy_q;
  assign wr_ok = bus_req && bus_wr && !sr_busy_q;

  always_comb begin
    unique case (bus_addr)
      ADDR_W'(OFF_CTRL), ADDR_W'(OFF_CNT), ADDR_W'(OFF_LOAD),
      ADDR_W'(OFF_TRIG), ADDR_W'(OFF_MATCH): wr_posted = wr_ok;
      default:                               wr_posted = 1'b0;
    endcase
  end

  gpt_post #(.AW(ADDR_W), .DW(DATA_W), .LAT(POST_LAT)) u_post (
    .clk(clk), .rst_n(rst_i), .clr(clr), .wr_en(wr_posted),
    .wr_addr(bus_addr), .wr_data(bus_wdata), .busy(post_busy),
    .apply(post_apply), .ap_addr(ap_addr), .ap_data(ap_data)
  );

  assign ap_ctrl  = post_apply && (ap_addr == ADDR_W'(OFF_CTRL));
  assign ap_cnt   = post_apply && (ap_addr == ADDR_W'(OFF_CNT));
  assign ap_load  = post_apply && (ap_addr == ADDR_W'(OFF_LOAD));
  assign ap_trig  = post_apply && (ap_addr == ADDR_W'(OFF_TRIG));
  assign ap_match = post_apply && (ap_addr == ADDR_W'(OFF_MATCH));

  gpt_prescale #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_i), .run(ctrl_q[CB_RUN] && !clr),
    .div_en(ctrl_q[CB_DIV_EN]), .div_sel(ctrl_q[CB_DIV_LO +: 3]), .tick(tick)
  );

  assign ovf_ev = tick && (cnt_q == '1);
  assign cmp_ev = tick && ctrl_q[CB_CMP_EN] && (cnt_q == match_q);

  gpt_pwm u_pwm (
    .clk(clk), .rst_n(rst_i), .clr(clr), .ovf_ev(ovf_ev), .cmp_ev(cmp_ev),
    .evt_sel(ctrl_q[CB_EVT_LO +: 2]), .toggle(ctrl_q[CB_TOGGLE]),
    .idle_lvl(ctrl_q[CB_IDLE]), .pwm_out(pwm_out)
  );

  // next state
  always_comb begin
    ctrl_d  = ctrl_q;
    cnt_d   = cnt_q;
    load_d  = load_q;
    match_d = match_q;
    ien_d   = ien_q;
    stat_w1c = (wr_ok && bus_addr == ADDR_W'(OFF_STAT)) ? bus_wdata[STAT_W-1:0] : '0;
    stat_d  = stat_q & ~stat_w1c;
    stat_d[SB_CMP] = stat_d[SB_CMP] | cmp_ev;
    stat_d[SB_OVF] = stat_d[SB_OVF] | ovf_ev;
    if (wr_ok && bus_addr == ADDR_W'(OFF_IEN)) ien_d = bus_wdata[STAT_W-1:0];
    if (ap_load)  load_d  = ap_data;
    if (ap_match) match_d = ap_data;

    if (ap_cnt)       cnt_d = ap_data;
    else if (ap_trig) cnt_d = load_q;
    else if (ovf_ev)  cnt_d = ctrl_q[CB_AUTO] ? load_q : '0;
    else if (tick)    cnt_d = cnt_q + 1'b1;

    if (ap_ctrl)                          ctrl_d = ap_data[CTRL_W-1:0];
    else if (ovf_ev && !ctrl_q[CB_AUTO])  ctrl_d[CB_RUN] = 1'b0;

    sr_go     = wr_ok && (bus_addr == ADDR_W'(OFF_IFC)) && bus_wdata[1];
    sr_busy_d = sr_busy_q;
    sr_cnt_d  = sr_cnt_q;
    if (sr_go) begin
      sr_busy_d = 1'b1;
      sr_cnt_d  = SRW'(SR_LAT - 1);
    end else if (sr_busy_q) begin
      if (sr_cnt_q == '0) sr_busy_d = 1'b0;
      else                sr_cnt_d  = sr_cnt_q - 1'b1;
    end

    if (clr) begin
      ctrl_d  = '0;
      cnt_d   = '0;
      load_d  = '0;
      match_d = '0;
      stat_d  = '0;
      ien_d   = '0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctrl_q    <= '0;
      cnt_q     <= '0;
      load_q    <= '0;
      match_q   <= '0;
      stat_q    <= '0;
      ien_q     <= '0;
      sr_busy_q <= 1'b0;
      sr_cnt_q  <= '0;
    end else begin
      ctrl_q    <= ctrl_d;
      cnt_q     <= cnt_d;
      load_q    <= load_d;
      match_q   <= match_d;
      stat_q    <= stat_d;
      ien_q     <= ien_d;
      sr_busy_q <= sr_busy_d;
      sr_cnt_q  <= sr_cnt_d;
    end
  end

  always_comb begin
    pend_code = '0;
    if (post_busy) begin
      pend_code[0] = (ap_addr == ADDR_W'(OFF_CTRL));
      pend_code[1] = (ap_addr == ADDR_W'(OFF_CNT));
      pend_code[2] = (ap_addr == ADDR_W'(OFF_LOAD));
      pend_code[3] = (ap_addr == ADDR_W'(OFF_TRIG));
      pend_code[4] = (ap_addr == ADDR_W'(OFF_MATCH));
    end
  end

  always_comb begin
    unique case (bus_addr)
      ADDR_W'(OFF_SYSST): bus_rdata = DATA_W'(!sr_busy_q);
      ADDR_W'(OFF_STAT):  bus_rdata = DATA_W'(stat_q);
      ADDR_W'(OFF_IEN):   bus_rdata = DATA_W'(ien_q);
      ADDR_W'(OFF_CTRL):  bus_rdata = DATA_W'(ctrl_q);
      ADDR_W'(OFF_CNT):   bus_rdata = cnt_q;
      ADDR_W'(OFF_LOAD):  bus_rdata = load_q;
      ADDR_W'(OFF_PEND):  bus_rdata = DATA_W'(pend_code);
      ADDR_W'(OFF_MATCH): bus_rdata = match_q;
      default:            bus_rdata = '0;
    endcase
  end

  assign irq = |(stat_q & ien_q);
endmodule

// File: rtl/gpt_chk.sv
module gpt_chk
  import gpt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              irq,
  input logic              pwm_out,
  input logic [CTRL_W-1:0] ctrl_q,
  input logic [DATA_W-1:0] cnt_q,
  input logic [STAT_W-1:0] stat_q,
  input logic              sr_busy_q,
  input logic              post_busy,
  input logic              ap_ctrl,
  input logic              tick
);
  logic posted_wr;
  assign posted_wr = bus_req && bus_wr && !sr_busy_q &&
    ((bus_addr == ADDR_W'(OFF_CTRL)) || (bus_addr == ADDR_W'(OFF_CNT)) ||
     (bus_addr == ADDR_W'(OFF_LOAD)) || (bus_addr == ADDR_W'(OFF_TRIG)) ||
     (bus_addr == ADDR_W'(OFF_MATCH)));

  AST_PEND_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    posted_wr |=> post_busy); // R2

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[CB_RUN] && !post_busy && !sr_busy_q) |=> $stable(cnt_q)); // R4

  AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt_q == '1 && !ctrl_q[CB_AUTO] && !ap_ctrl) |=> !ctrl_q[CB_RUN]); // R6

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_q != '0)); // R8

  AST_PIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ctrl_q[CB_EVT_LO +: 2]) == 2'd0 && ctrl_q[CB_EVT_LO +: 2] == 2'd0 &&
     $stable(ctrl_q[CB_IDLE])) |-> (pwm_out == ctrl_q[CB_IDLE])); // R9

  AST_SOFT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sr_busy_q |=> (cnt_q == '0 && ctrl_q == '0 && stat_q == '0)); // R10
endmodule

bind gpt_timer gpt_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_i), .bus_req(bus_req), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .irq(irq), .pwm_out(pwm_out), .ctrl_q(ctrl_q),
  .cnt_q(cnt_q), .stat_q(stat_q), .sr_busy_q(sr_busy_q),
  .post_busy(post_busy), .ap_ctrl(ap_ctrl), .tick(tick)
);

// File: tb/test_gpt_timer.sv
module test_gpt_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        irq, pwm_out;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  gpt_timer i_gpt_timer (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .pwm_out(pwm_out)
  );

  localparam logic [7:0] A_SYS = 8'h14, A_ST = 8'h18, A_IE = 8'h1C,
    A_CTL = 8'h24, A_CNT = 8'h28, A_LD = 8'h2C, A_TRG = 8'h30,
    A_PND = 8'h34, A_MT = 8'h38, A_IFC = 8'h40;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_post();
    logic [31:0] p;
    for (int i = 0; i < 50; i++) begin
      rd(A_PND, p);
      if (p == 0) break;
      @(negedge clk);
    end
  endtask

  task automatic pwr(logic [7:0] a, logic [31:0] d);
    wr(a, d);
    wait_post();
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(A_CTL, v); chk("R1", "control", v, 0);
    rd(A_CNT, v); chk("R1", "counter", v, 0);
    rd(A_LD, v);  chk("R1", "start value", v, 0);
    rd(A_MT, v);  chk("R1", "compare", v, 0);
    rd(A_ST, v);  chk("R1", "status", v, 0);
    rd(A_IE, v);  chk("R1", "enable", v, 0);
    rd(A_SYS, v); chk("R1", "reset done", v, 1);
    chk("R1", "irq", {31'b0, irq}, 0);
    chk("R1", "pin", {31'b0, pwm_out}, 0);
  endtask

  task automatic t_posted();
    logic [31:0] v;
    wr(A_LD, 32'h55);
    rd(A_PND, v); chk("R2", "pending code", v, 32'h4);
    rd(A_LD, v);  chk("R2", "old value while pending", v, 0);
    wait_post();
    rd(A_LD, v);  chk("R2", "value after pending", v, 32'h55);
    wr(A_MT, 32'h9);
    rd(A_PND, v); chk("R2", "pending code compare", v, 32'h10);
    wait_post();
    pwr(A_CNT, 32'h10);
    rd(A_CNT, v); chk("R2", "direct counter write", v, 32'h10);
  endtask

  task automatic t_trigger();
    logic [31:0] v;
    pwr(A_TRG, 32'hDEAD);
    rd(A_CNT, v); chk("R3", "counter after trigger", v, 32'h55);
  endtask

  task automatic t_count();
    logic [31:0] a, b;
    pwr(A_CTL, 32'h1);
    rd(A_CNT, a); idle(20); rd(A_CNT, b);
    chk("R4", "steps in 20 clocks", b - a, 20);
    pwr(A_CTL, 32'h0);
    rd(A_CNT, a); idle(10); rd(A_CNT, b);
    chk("R4", "held when stopped", b, a);
  endtask

  task automatic t_prescale();
    logic [31:0] a, b;
    pwr(A_CTL, 32'h25);
    idle(10); rd(A_CNT, a); idle(40); rd(A_CNT, b);
    chk("R5", "divide by 4", b - a, 10);
    pwr(A_CTL, 32'h21);
    idle(10); rd(A_CNT, a); idle(40); rd(A_CNT, b);
    chk("R5", "divide by 2", b - a, 20);
    pwr(A_CTL, 32'h3D);
    idle(300); rd(A_CNT, a); idle(512); rd(A_CNT, b);
    chk("R5", "divide by 256", b - a, 2);
    pwr(A_CTL, 32'h0);
  endtask

  task automatic t_oneshot();
    logic [31:0] v;
    pwr(A_LD, 32'hFFFF_FFF0);
    pwr(A_TRG, 0);
    wr(A_ST, 32'h7);
    pwr(A_CTL, 32'h1);
    idle(40);
    rd(A_CNT, v); chk("R6", "wrapped counter", v, 0);
    rd(A_CTL, v); chk("R6", "run bit cleared", v, 0);
    rd(A_ST, v);  chk("R6", "overflow flag", v, 32'h2);
    chk("R8", "irq masked", {31'b0, irq}, 0);
    wr(A_IE, 32'h2);
    chk("R8", "irq enabled", {31'b0, irq}, 1);
    wr(A_ST, 32'h2);
    chk("R8", "irq after clear", {31'b0, irq}, 0);
    rd(A_ST, v);  chk("R8", "status after clear", v, 0);
    wr(A_IE, 32'h0);
  endtask

  task automatic t_autoreload();
    logic [31:0] v;
    pwr(A_TRG, 0);
    pwr(A_CTL, 32'h3);
    idle(100);
    rd(A_CTL, v); chk("R6", "still running", v, 32'h3);
    rd(A_CNT, v); chk("R6", "reloaded range", {31'b0, v >= 32'hFFFF_FFF0}, 1);
    rd(A_ST, v);  chk("R6", "overflow flag auto", v, 32'h2);
    pwr(A_CTL, 32'h0);
    wr(A_ST, 32'h7);
  endtask

  task automatic t_match();
    logic [31:0] v;
    pwr(A_LD, 32'd100);
    pwr(A_TRG, 0);
    pwr(A_MT, 32'd105);
    pwr(A_CTL, 32'h41);
    idle(20);
    rd(A_ST, v); chk("R7", "compare flag", v, 32'h1);
    pwr(A_CTL, 32'h0);
    wr(A_ST, 32'h7);
    pwr(A_TRG, 0);
    pwr(A_CTL, 32'h1);
    idle(20);
    rd(A_ST, v); chk("R7", "no compare when disabled", v, 0);
    pwr(A_CTL, 32'h0);
  endtask

  task automatic count_level(bit lvl, output int n);
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pwm_out == lvl) n++;
    end
  endtask

  task automatic t_pwm();
    int n;
    logic prev;
    pwr(A_LD, 32'hFFFF_FFFC);
    pwr(A_TRG, 0);
    pwr(A_CTL, 32'h1403);
    idle(8);
    n = 0; prev = pwm_out;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pwm_out != prev) n++;
      prev = pwm_out;
    end
    chk("R9", "toggles on overflow", n, 10);
    pwr(A_CTL, 32'h0483);
    idle(8); count_level(1'b0, n);
    chk("R9", "pulses from high idle", n, 10);
    pwr(A_MT, 32'hFFFF_FFFD);
    pwr(A_CTL, 32'h0843);
    idle(8); count_level(1'b1, n);
    chk("R9", "pulses on overflow or compare", n, 20);
    pwr(A_CTL, 32'h0C43);
    idle(8); count_level(1'b1, n);
    chk("R9", "select 3 gives no events", n, 0);
    pwr(A_CTL, 32'h0080);
    idle(2);
    chk("R9", "idle high", {31'b0, pwm_out}, 1);
    pwr(A_CTL, 32'h0);
    idle(2);
    chk("R9", "idle low", {31'b0, pwm_out}, 0);
  endtask

  task automatic t_softreset();
    logic [31:0] v;
    pwr(A_LD, 32'h1234);
    pwr(A_CTL, 32'h2);
    wr(A_IE, 32'h3);
    wr(A_IFC, 32'h1);
    rd(A_SYS, v); chk("R10", "bit 1 clear ignored", v, 1);
    rd(A_LD, v);  chk("R10", "value kept", v, 32'h1234);
    wr(A_IFC, 32'h6);
    rd(A_SYS, v); chk("R10", "reset in progress", v, 0);
    wr(A_LD, 32'h77);
    rd(A_PND, v); chk("R10", "write ignored during reset", v, 0);
    for (int i = 0; i < 50; i++) begin
      rd(A_SYS, v);
      if (v == 1) break;
      @(negedge clk);
    end
    chk("R10", "reset done", v, 1);
    rd(A_LD, v);  chk("R10", "start value cleared", v, 0);
    rd(A_CTL, v); chk("R10", "control cleared", v, 0);
    rd(A_IE, v);  chk("R10", "enable cleared", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_posted();
    t_trigger();
    t_count();
    t_prescale();
    t_oneshot();
    t_autoreload();
    t_match();
    t_pwm();
    t_softreset();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule